// File: doc/BRIEF.md
# Subtractive Checksum Block Watchdog

This checker runs beside a processor and watches its control flow one code block at a time. When a block begins, the processor hands over a reference value: the sum of all instruction codes that the block should fetch, in a width that cannot wrap. Each instruction fetch seen while a block is open takes its code off that reference. When the block ends, the processor asks for a zero check. A remainder of exactly zero means the block ran in full and in order. Any other remainder is reported as a mismatch.

The remainder has a sign bit above the widest possible reference. If a fetch would take the remainder below zero before the zero check arrives, the block has run longer than its reference allows. That case is reported as an overrun, so the same datapath also does the job of a timeout watchdog. After a pass or either error the checker goes back to idle and waits for the next reference. Error flags stay set until that next reference arrives.

The control has two named states. `ST_IDLE` waits for a reference. `ST_RUN` is a block in progress. The transitions are:
- LOAD: `ST_IDLE`/`ST_RUN` → `ST_RUN`
- STEP: `ST_RUN` → `ST_RUN`, a fetch that leaves a non-negative remainder
- PASS: `ST_RUN` → `ST_IDLE`, zero check with a zero remainder
- MISMATCH: `ST_RUN` → `ST_IDLE`, zero check with a nonzero remainder
- OVERRUN: `ST_RUN` → `ST_IDLE`, a fetch that would go negative

Top module: `sumdown_watchdog`

## Requirements
- R1: While reset is asserted and after it is released, `block_active`, `check_pass`, `err_mismatch` and `err_overrun` are all 0.
- R2: A cycle with `ref_load` high, in either state, sets `block_active` after that edge, clears both error flags, and makes `ref_value` the new remainder.
- R3: Each cycle in `ST_RUN` with `fetch_valid` high, and with neither `ref_load` nor `zero_check` high, subtracts `fetch_code` (zero-extended) from the remainder. Reaching exactly zero this way is not an error.
- R4: A `zero_check` in `ST_RUN` with a zero remainder gives a one-cycle `check_pass` pulse and returns to `ST_IDLE`.
- R5: A `zero_check` in `ST_RUN` with a nonzero remainder sets `err_mismatch` and returns to `ST_IDLE`.
- R6: A fetch in `ST_RUN` whose code exceeds the remainder sets `err_overrun` and returns to `ST_IDLE`. The remainder never wraps.
- R7: In `ST_IDLE`, `fetch_valid` and `zero_check` have no effect: the checker stays idle, `check_pass` stays 0, and both error flags keep their values.
- R8: When several commands arrive in one cycle, `ref_load` wins over `zero_check` and `fetch_valid`, and `zero_check` wins over `fetch_valid`. The losing commands are discarded.
- R9: `err_mismatch` and `err_overrun` hold their value until the next `ref_load`. At most one of `check_pass`, `err_mismatch` and `err_overrun` is high at a time.
- R10: The remainder is GUARD_W bits wider than an instruction code, including its sign. With the default widths, a reference of 32767 absorbs 128 fetches of code 255 plus one fetch of 127 and then passes the zero check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_load | input | 1 | Start a block with `ref_value` as the reference sum |
| ref_value | input | INSTR_W+GUARD_W-1 | Reference sum of the block's instruction codes |
| fetch_valid | input | 1 | An instruction fetch happens this cycle |
| fetch_code | input | INSTR_W | Code of the fetched instruction |
| zero_check | input | 1 | End of block: test the remainder for zero |
| block_active | output | 1 | A block is in progress (`ST_RUN`) |
| check_pass | output | 1 | One-cycle pulse: the zero check found zero |
| err_mismatch | output | 1 | Sticky: the zero check found a nonzero remainder |
| err_overrun | output | 1 | Sticky: the remainder would have gone negative |

## Verification
The hardest case to reach from the ports is an overrun on exactly the fetch that crosses zero. A near-miss on either side has to be told apart from it: a remainder that lands exactly on zero by fetch and then passes, or one that stays one above zero and then mismatches. The bench sweeps seeded code sequences of lengths 0 to 8. It loads each block's true sum offset by -2 to +3. For every fetch it works out the running remainder arithmetically, so it knows which fetch must raise the overrun. A separate run at the widest reference drives the remainder through its full range.

// File: rtl/sdw_pkg.sv
package sdw_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sdw_state_e;
endpackage

// File: rtl/sdw_remainder.sv
module sdw_remainder #(
    parameter int INSTR_W = 8,
    parameter int GUARD_W = 8,
    localparam int REM_W  = INSTR_W + GUARD_W,
    localparam int REF_W  = REM_W - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               sub_en,
    input  logic [REF_W-1:0]   ref_value,
    input  logic [INSTR_W-1:0] fetch_code,
    output logic               rem_zero,
    output logic               sub_neg
);
    logic [REM_W-1:0] rem_q;
    logic [REM_W-1:0] diff;

    // Sign lives in the top bit; the reference enters zero-extended.
    assign diff     = rem_q - {{GUARD_W{1'b0}}, fetch_code};
    assign sub_neg  = diff[REM_W-1];
    assign rem_zero = (rem_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load_en) begin
            rem_q <= {1'b0, ref_value};
        end else if (sub_en) begin
            rem_q <= diff;
        end
    end
endmodule

// File: rtl/sdw_ctrl.sv
module sdw_ctrl
    import sdw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_load,
    input  logic fetch_valid,
    input  logic zero_check,
    input  logic rem_zero,
    input  logic sub_neg,
    output logic load_en,
    output logic sub_en,
    output logic block_active,
    output logic check_pass,
    output logic err_mismatch,
    output logic err_overrun
);
    sdw_state_e state_q, state_d;
    logic ev_check, ev_fetch, ev_over;
    logic pass_q, mis_q, over_q;

    // Command arbitration: load > zero check > fetch; idle ignores the rest.
    always_comb begin
        load_en  = ref_load;
        ev_check = 1'b0;
        ev_fetch = 1'b0;
        state_d  = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_load) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ref_load) begin
                    if (zero_check) begin
                        ev_check = 1'b1;
                        state_d  = ST_IDLE;
                    end else if (fetch_valid) begin
                        ev_fetch = 1'b1;
                        if (sub_neg) state_d = ST_IDLE;
                    end
                end
            end
        endcase
        ev_over = ev_fetch & sub_neg;
        sub_en  = ev_fetch & ~sub_neg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pass_q <= 1'b0;
            mis_q  <= 1'b0;
            over_q <= 1'b0;
        end else begin
            pass_q <= ev_check & rem_zero;
            if (ref_load) begin
                mis_q  <= 1'b0;
                over_q <= 1'b0;
            end else begin
                if (ev_check && !rem_zero) mis_q  <= 1'b1;
                if (ev_over)               over_q <= 1'b1;
            end
        end
    end

    assign block_active = (state_q == ST_RUN);
    assign check_pass   = pass_q;
    assign err_mismatch = mis_q;
    assign err_overrun  = over_q;
endmodule

// File: rtl/sumdown_watchdog.sv
module sumdown_watchdog #(
    parameter int INSTR_W = 8,
    parameter int GUARD_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ref_load,
    input  logic [INSTR_W+GUARD_W-2:0] ref_value,
    input  logic                       fetch_valid,
    input  logic [INSTR_W-1:0]         fetch_code,
    input  logic                       zero_check,
    output logic                       block_active,
    output logic                       check_pass,
    output logic                       err_mismatch,
    output logic                       err_overrun
);
    logic load_en, sub_en, rem_zero, sub_neg;

    sdw_remainder #(.INSTR_W(INSTR_W), .GUARD_W(GUARD_W)) u_rem (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .sub_en     (sub_en),
        .ref_value  (ref_value),
        .fetch_code (fetch_code),
        .rem_zero   (rem_zero),
        .sub_neg    (sub_neg)
    );

    sdw_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_load     (ref_load),
        .fetch_valid  (fetch_valid),
        .zero_check   (zero_check),
        .rem_zero     (rem_zero),
        .sub_neg      (sub_neg),
        .load_en      (load_en),
        .sub_en       (sub_en),
        .block_active (block_active),
        .check_pass   (check_pass),
        .err_mismatch (err_mismatch),
        .err_overrun  (err_overrun)
    );
endmodule

// File: rtl/sdw_checker.sv
module sdw_checker (
    input logic clk,
    input logic rst_n,
    input logic ref_load,
    input logic fetch_valid,
    input logic zero_check,
    input logic block_active,
    input logic check_pass,
    input logic err_mismatch,
    input logic err_overrun
);
    a_r2_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load |=> (block_active && !err_mismatch && !err_overrun));

    a_r7_idle_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!block_active && !ref_load) |=>
        (!block_active && !check_pass && $stable(err_mismatch) && $stable(err_overrun)));

    a_r4_pass_source: assert property (@(posedge clk) disable iff (!rst_n)
        check_pass |-> $past(block_active && zero_check && !ref_load));

    a_r4_check_ends_block: assert property (@(posedge clk) disable iff (!rst_n)
        (block_active && zero_check && !ref_load) |=> !block_active);

    a_r5_mismatch_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_mismatch) |-> $past(block_active && zero_check && !ref_load));

    a_r6_overrun_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_overrun) |-> $past(block_active && fetch_valid && !zero_check && !ref_load));

    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({check_pass, err_mismatch, err_overrun}));
endmodule

bind sumdown_watchdog sdw_checker u_sdw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .ref_load     (ref_load),
    .fetch_valid  (fetch_valid),
    .zero_check   (zero_check),
    .block_active (block_active),
    .check_pass   (check_pass),
    .err_mismatch (err_mismatch),
    .err_overrun  (err_overrun)
);

// File: tb/sumdown_watchdog_test.sv
module sumdown_watchdog_test;
    localparam int INSTR_W = 8;
    localparam int GUARD_W = 8;
    localparam int REF_W   = INSTR_W + GUARD_W - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_load = 1'b0;
    logic [REF_W-1:0] ref_value = '0;
    logic fetch_valid = 1'b0;
    logic [INSTR_W-1:0] fetch_code = '0;
    logic zero_check = 1'b0;
    logic block_active, check_pass, err_mismatch, err_overrun;

    int total = 0;
    int bad = 0;

    always #2ns clk = ~clk;

    sumdown_watchdog #(.INSTR_W(INSTR_W), .GUARD_W(GUARD_W)) uut (
        .clk(clk), .rst_n(rst_n), .ref_load(ref_load), .ref_value(ref_value),
        .fetch_valid(fetch_valid), .fetch_code(fetch_code), .zero_check(zero_check),
        .block_active(block_active), .check_pass(check_pass),
        .err_mismatch(err_mismatch), .err_overrun(err_overrun)
    );

    // observed vector: {active, pass, mismatch, overrun}
    function automatic logic [3:0] obs();
        return {block_active, check_pass, err_mismatch, err_overrun};
    endfunction

    task automatic expect_obs(string req, logic [3:0] exp);
        total++;
        if (obs() !== exp) begin
            bad++;
            $display("FAIL %s: act=%b exp=%b (active,pass,mis,over)", req, obs(), exp);
        end
    endtask

    // Drive one cycle of commands at a falling edge, release at the next one.
    task automatic step(bit ld, int rv, bit fv, int code, bit zc);
        @(negedge clk);
        ref_load    = ld;
        ref_value   = REF_W'(rv);
        fetch_valid = fv;
        fetch_code  = INSTR_W'(code);
        zero_check  = zc;
        @(negedge clk);
        ref_load    = 1'b0;
        fetch_valid = 1'b0;
        zero_check  = 1'b0;
    endtask

    function automatic int fcode(int seed, int i);
        return (seed * 37 + i * 53 + 11) % 256;
    endfunction

    task automatic run_block(int seed, int n, int delta);
        int sum = 0;
        int rem;
        bit over = 0;
        for (int i = 0; i < n; i++) sum += fcode(seed, i);
        if (sum + delta < 0) return;
        rem = sum + delta;
        step(1, rem, 0, 0, 0);
        expect_obs("R2", 4'b1000);
        for (int i = 0; i < n; i++) begin
            int c = fcode(seed, i);
            step(0, 0, 1, c, 0);
            rem -= c;
            if (rem < 0) begin
                expect_obs("R6", 4'b0001);
                over = 1;
                break;
            end
            expect_obs("R3", 4'b1000);
        end
        if (!over) begin
            step(0, 0, 0, 0, 1);
            if (rem == 0) expect_obs("R4", 4'b0100);
            else          expect_obs("R5", 4'b0010);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: act=hung exp=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        expect_obs("R1 in reset", 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        expect_obs("R1 after reset", 4'b0000);

        // R7: commands while idle are ignored
        step(0, 0, 1, 9, 0);
        expect_obs("R7 idle fetch", 4'b0000);
        step(0, 0, 0, 0, 1);
        expect_obs("R7 idle check", 4'b0000);

        // R4: pulse lasts one cycle
        step(1, 7, 0, 0, 0);
        step(0, 0, 1, 7, 0);
        expect_obs("R3 exact zero by fetch", 4'b1000);
        step(0, 0, 0, 0, 1);
        expect_obs("R4 pass", 4'b0100);
        @(negedge clk);
        expect_obs("R4 pulse ends", 4'b0000);

        // R8: check beats fetch in the same cycle
        step(1, 5, 0, 0, 0);
        step(0, 0, 1, 5, 1);
        expect_obs("R8 check over fetch", 4'b0010);

        // R9: flag holds through idle and ignored commands
        repeat (3) @(negedge clk);
        step(0, 0, 1, 1, 1);
        expect_obs("R9 hold mismatch", 4'b0010);

        // R8: load beats check; R2 clears flags
        step(1, 3, 0, 0, 1);
        expect_obs("R8 load over check", 4'b1000);
        step(1, 4, 1, 3, 1);
        expect_obs("R8 load over fetch", 4'b1000);
        step(0, 0, 1, 4, 0);
        step(0, 0, 0, 0, 1);
        expect_obs("R2 reload value used", 4'b0100);

        // R6 then R9 hold of overrun
        step(1, 2, 0, 0, 0);
        step(0, 0, 1, 3, 0);
        expect_obs("R6 overrun", 4'b0001);
        step(0, 0, 1, 0, 0);
        expect_obs("R9 hold overrun", 4'b0001);

        // R10: widest reference
        step(1, 32767, 0, 0, 0);
        for (int i = 0; i < 128; i++) step(0, 0, 1, 255, 0);
        expect_obs("R10 after 128 fetches", 4'b1000);
        step(0, 0, 1, 127, 0);
        step(0, 0, 0, 0, 1);
        expect_obs("R10 full range pass", 4'b0100);
        step(1, 32767, 0, 0, 0);
        for (int i = 0; i < 129; i++) step(0, 0, 1, 255, 0);
        expect_obs("R10 full range overrun", 4'b0001);

        // Sweep: seeds x lengths x reference offsets
        for (int s = 0; s < 8; s++)
            for (int n = 0; n <= 8; n++)
                for (int d = -2; d <= 3; d++)
                    run_block(s, n, d);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule